// File: doc/BRIEF.md
# Three-Channel Match-Compare Timer

The block is a memory-mapped timer with a parameterised number of up-counters (three by default). Each counter advances by one on every bus clock in which the shared tick-enable input is high and the counter's own enable bit is set. Each counter has its own bank of match comparators (three by default). When a comparator matches on a tick, it sets a sticky status bit. The status bits are gated by per-comparator enable bits and OR-ed into one level interrupt.

Each counter runs in one of two modes. In the free mode it wraps around past its matches. In the reload mode comparator 0 pulls it back to zero, which gives a periodic event. Software reads a counter through a capture slot. A write to that slot takes a snapshot, the snapshot crosses a fixed settling delay, and software then reads it from the same address.

Top module: `match_timer`

## Requirements
- R1: The global register at byte address 0x00 holds one run bit per timer (bit t runs timer t). A timer whose run bit is 0 holds its count.
- R2: A write to 0x00 that changes a timer's run bit from 0 to 1 restarts that timer's count at 0.
- R3: In free mode, a running timer adds 1 on each clock with `tick_en` high and wraps modulo 2^CW.
- R4: Timer t's registers sit at base (t+1)*0x40. Comparator c's match value is at base+4*c. Status bit c (register base+0x20) sets on the tick where the count equals that match value, so a value of N-1 after a restart gives the event on tick N.
- R5: Bit 0 of the mode register (base+0x28) set to 1 selects reload: on a comparator-0 tick the count goes to 0 instead of advancing, which gives a period of match+1 ticks.
- R6: Writing a 1 to a status bit clears it. Bits written as 0 keep their value.
- R7: If a comparator hit and a clear of the same status bit land in the same cycle, the bit ends up set.
- R8: `irq` is high while any status bit has its enable bit set in the enable register (base+0x24). It stays high until software clears the status or the enable.
- R9: A write to the capture slot (base+0x2C) snapshots the count. Reads of that slot return the previous snapshot until CAP_LAT (4) clocks have passed. Busy bit t in the global register 0x04 is high during that time.
- R10: After reset, all counts, run bits, status, enables, match values and snapshots are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-advance qualifier |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte address |
| wdata | input | DW | Write data |
| rd_data | output | DW | Read data for `addr`, combinational |
| irq | output | 1 | Combined level interrupt |

## Verification
The bench builds the block with an 8-bit counter width and default values for the rest. With 8 bits, a free-running counter wraps after 256 ticks, so modulo wrap-around can be checked in a short run. With all three timers present, every timer address slot and the per-timer independence of run bits get exercised. A capture latency of 4 keeps the stale-snapshot window short enough to probe clock by clock.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int NT      = 3,
  parameter int NC      = 3,
  parameter int CW      = 32,
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter int CAP_LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam int TSW = AW - 6;
  localparam int DLW = $clog2(CAP_LAT + 1);
  localparam logic [3:0] OFF_STS = 4'd8;
  localparam logic [3:0] OFF_IE  = 4'd9;
  localparam logic [3:0] OFF_MOD = 4'd10;
  localparam logic [3:0] OFF_CAP = 4'd11;

  logic [TSW-1:0] tsel;
  logic [3:0]     off;
  logic           gsel, en_wr;

  logic [NT-1:0]                 en_q, per_q, busy;
  logic [NT-1:0][CW-1:0]         cnt, cap_q, cap_pend;
  logic [NT-1:0][NC-1:0][CW-1:0] mval;
  logic [NT-1:0][NC-1:0]         sts, ie, hit;
  logic [NT-1:0][DLW-1:0]        dly;

  assign tsel  = addr[AW-1:6];
  assign off   = addr[5:2];
  assign gsel  = (tsel == '0);
  assign en_wr = wr_en && gsel && (off == 4'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en_q <= '0;
    else if (en_wr) en_q <= wdata[NT-1:0];

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic sel;
    logic [NC-1:0] clr;
    assign sel = wr_en && (tsel == TSW'(t + 1));
    assign clr = (sel && off == OFF_STS) ? wdata[NC-1:0] : '0;
    assign busy[t] = (dly[t] != '0);

    for (genvar c = 0; c < NC; c++) begin : g_cmp
      assign hit[t][c] = en_q[t] && tick_en && (cnt[t] == mval[t][c]);
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) mval[t][c] <= '0;
        else if (sel && off == 4'(c)) mval[t][c] <= wdata[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sts[t]   <= '0;
        ie[t]    <= '0;
        per_q[t] <= 1'b0;
      end else begin
        sts[t] <= (sts[t] & ~clr) | hit[t];
        if (sel && off == OFF_IE)  ie[t]    <= wdata[NC-1:0];
        if (sel && off == OFF_MOD) per_q[t] <= wdata[0];
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) cnt[t] <= '0;
      else if (en_wr && wdata[t] && !en_q[t]) cnt[t] <= '0;
      else if (en_q[t] && tick_en)
        cnt[t] <= (per_q[t] && hit[t][0]) ? '0 : cnt[t] + 1'b1;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        dly[t]      <= '0;
        cap_pend[t] <= '0;
        cap_q[t]    <= '0;
      end else if (sel && off == OFF_CAP) begin
        dly[t]      <= DLW'(CAP_LAT);
        cap_pend[t] <= cnt[t];
      end else if (busy[t]) begin
        dly[t] <= dly[t] - 1'b1;
        if (dly[t] == DLW'(1)) cap_q[t] <= cap_pend[t];
      end
  end

  always_comb begin
    rd_data = '0;
    if (gsel) begin
      if (off == 4'd0) rd_data[NT-1:0] = en_q;
      if (off == 4'd1) rd_data[NT-1:0] = busy;
    end
    for (int t = 0; t < NT; t++) begin
      if (tsel == TSW'(t + 1)) begin
        for (int c = 0; c < NC; c++)
          if (off == 4'(c)) rd_data[CW-1:0] = mval[t][c];
        case (off)
          OFF_STS: rd_data[NC-1:0] = sts[t];
          OFF_IE:  rd_data[NC-1:0] = ie[t];
          OFF_MOD: rd_data[0]      = per_q[t];
          OFF_CAP: rd_data[CW-1:0] = cap_q[t];
          default: ;
        endcase
      end
    end
  end

  assign irq = |(sts & ie);
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int NT = 3,
  parameter int NC = 3,
  parameter int CW = 32,
  parameter int AW = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tick_en,
  input logic                          wr_en,
  input logic [AW-1:0]                 addr,
  input logic                          irq,
  input logic [NT-1:0]                 en_q,
  input logic [NT-1:0]                 per_q,
  input logic [NT-1:0]                 busy,
  input logic [NT-1:0][CW-1:0]         cnt,
  input logic [NT-1:0][NC-1:0][CW-1:0] mval,
  input logic [NT-1:0][NC-1:0]         sts
);
  logic run_wr;
  assign run_wr = wr_en && (addr == '0);

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_en) |=> irq); // R8

  for (genvar t = 0; t < NT; t++) begin : g_t
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[t] && !run_wr) |=> $stable(cnt[t])); // R1
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q[t]) |-> (cnt[t] == '0)); // R2
    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[t] && tick_en && !per_q[t] && !run_wr)
        |=> (cnt[t] == $past(cnt[t]) + CW'(1))); // R3
    AST_PERIOD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[t] && tick_en && per_q[t] && cnt[t] == mval[t][0] && !run_wr)
        |=> (cnt[t] == '0)); // R5
    AST_CAP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'((t + 1) * 64 + 44)) |=> busy[t]); // R9
    for (genvar c = 0; c < NC; c++) begin : g_c
      AST_MATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[t] && tick_en && cnt[t] == mval[t][c]) |=> sts[t][c]); // R4 R7
      AST_STS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[t][c] && !wr_en) |=> sts[t][c]); // R6
    end
  end
endmodule

bind match_timer match_timer_chk #(.NT(NT), .NC(NC), .CW(CW), .AW(AW)) u_chk (.*);

// File: tb/match_timer_bench.sv
module match_timer_bench;
  localparam int CW = 8;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic        irq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  match_timer #(.CW(CW)) u_match_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq(irq));

  function automatic logic [7:0] ta(int t, int o);
    return 8'((t + 1) * 64 + o);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic capture(int t, output logic [31:0] v);
    wr(ta(t, 8'h2C), 0);
    repeat (4) @(negedge clk);
    rd(ta(t, 8'h2C), v);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h00, v); chk("R10 run bits", v, 0);
    rd(ta(0, 8'h20), v); chk("R10 status", v, 0);
    rd(ta(2, 8'h2C), v); chk("R10 snapshot", v, 0);
    chk("R10 irq", irq, 0);
  endtask

  task automatic t_capture_count;
    logic [31:0] v;
    wr(8'h00, 1);
    ticks(10);
    wr(ta(0, 8'h2C), 0);
    rd(ta(0, 8'h2C), v); chk("R9 stale snapshot", v, 0);
    rd(8'h04, v); chk("R9 busy set", v, 1);
    repeat (3) @(negedge clk);
    rd(8'h04, v); chk("R9 busy at 3 clocks", v, 1);
    rd(ta(0, 8'h2C), v); chk("R9 still stale", v, 0);
    @(negedge clk);
    rd(8'h04, v); chk("R9 busy clear", v, 0);
    rd(ta(0, 8'h2C), v); chk("R3 count after 10 ticks", v, 10);
  endtask

  task automatic t_hold_restart;
    logic [31:0] v;
    wr(8'h00, 0);
    ticks(5);
    capture(0, v); chk("R1 stopped holds", v, 10);
    wr(8'h00, 1);
    ticks(3);
    capture(0, v); chk("R2 restart from 0", v, 3);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(8'h00, 0); wr(8'h00, 1);
    ticks(300);
    capture(0, v); chk("R3 wrap modulo 256", v, 300 % 256);
  endtask

  task automatic t_match_irq;
    logic [31:0] v;
    wr(ta(1, 8'h00), 4);
    wr(ta(1, 8'h04), 200);
    wr(ta(1, 8'h08), 201);
    wr(8'h00, 2);
    ticks(4);
    rd(ta(1, 8'h20), v); chk("R4 no hit before tick N", v, 0);
    ticks(1);
    rd(ta(1, 8'h20), v); chk("R4 hit on tick N", v, 1);
    chk("R8 masked irq low", irq, 0);
    wr(ta(1, 8'h24), 1);
    chk("R8 irq on enable", irq, 1);
    ticks(6);
    chk("R8 irq level holds", irq, 1);
    wr(ta(1, 8'h20), 6);
    rd(ta(1, 8'h20), v); chk("R6 zero bits keep", v, 1);
    wr(ta(1, 8'h20), 1);
    rd(ta(1, 8'h20), v); chk("R6 w1c clears", v, 0);
    chk("R8 irq drops", irq, 0);
  endtask

  task automatic t_periodic;
    logic [31:0] v;
    wr(ta(2, 8'h00), 3);
    wr(ta(2, 8'h04), 250);
    wr(ta(2, 8'h08), 251);
    wr(ta(2, 8'h28), 1);
    wr(8'h00, 4);
    ticks(4);
    rd(ta(2, 8'h20), v); chk("R5 first period hit", v, 1);
    capture(2, v); chk("R5 reloaded to 0", v, 0);
    wr(ta(2, 8'h20), 7);
    ticks(4);
    rd(ta(2, 8'h20), v); chk("R5 second period hit", v, 1);
    wr(ta(2, 8'h20), 1);
    ticks(3);
    // count is 3 == match: hit and clear on the same edge
    @(negedge clk);
    addr = ta(2, 8'h20); wdata = 1; wr_en = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    rd(ta(2, 8'h20), v); chk("R7 hit beats clear", v, 1);
    capture(2, v); chk("R5 reload on colliding tick", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_capture_count();
    t_hold_restart();
    t_wrap();
    t_match_irq();
    t_periodic();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule